// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves characters of `DATA_W` bits (8 by default) over a data-out line, a data-in line and one shared serial clock. Bits go out least-significant first. A transmitted bit changes on a falling edge of the serial clock. A received bit is captured on a rising edge. No parity or other extra bits are added. Transmit and receive each have one holding buffer in front of a shift register. The host can therefore queue the next byte, or collect the last one, while a character is still shifting, and characters follow one another with no idle time.

The serial clock has two possible sources. In internal mode, a programmable divider on the system clock produces the clock and drives it onto the clock pin, with the output enable raised. In external mode, the clock pin is an input: it passes through a synchronizer, and its edges are detected in the system clock domain. The host side is a set of plain strobes and flags: a write strobe with data, a read strobe with the held receive byte, a transmit-empty flag, a receive-full flag and an overrun flag.

Top module: `csync_xcvr`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `rx_ovr`=0, `sck_o`=1 and `sdo`=1.
- R2: Each character is exactly 8 bits, bit 0 first. `sdo` changes only when the block acts on a falling serial-clock edge, and it holds its value until the next falling edge.
- R3: The receiver captures `sdi` on each rising serial-clock edge. After 8 captures the assembled byte (first bit in bit 0) appears on `rx_data` and `rx_full` goes to 1.
- R4: In internal mode, `sck_oe`=1. Each character produces exactly 8 low pulses on `sck_o`. The first edge of a character is falling, the period is 2×(`divisor`+1) system clocks, and `sck_o` is high whenever no character is in progress.
- R5: After the last bit of a character, `sdo` keeps the value of that character's MSB until the next character starts.
- R6: A write clears `tx_empty`. `tx_empty` sets again when the byte moves into the shift register. If a byte is waiting when a character ends, the next falling edge comes exactly one clock period after the previous one, with no gap.
- R7: A write while `tx_empty`=0 is ignored, and the byte already waiting is the one that is sent.
- R8: If a character completes while `rx_full`=1, `rx_ovr` goes to 1 and the new byte is discarded (`rx_data` keeps the old one). A pulse on `rx_rd` clears both `rx_full` and `rx_ovr`.
- R9: In external mode, `sck_oe`=0 and `sck_o` stays high. Transmit bits change after each falling edge on `sck_i`, and receive bits are captured after each rising edge on `sck_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| int_clk_sel | input | 1 | 1 = internal divider clock, 0 = external clock on `sck_i` |
| divisor | input | DIV_W | Half-period of the internal clock, minus one, in system clocks |
| tx_data | input | DATA_W | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_empty | output | 1 | Transmit holding buffer is free |
| rx_data | output | DATA_W | Last received byte |
| rx_rd | input | 1 | Read strobe; clears `rx_full` and `rx_ovr` |
| rx_full | output | 1 | Unread byte in `rx_data` |
| rx_ovr | output | 1 | A byte was lost because `rx_data` was unread |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock, driven out |
| sck_oe | output | 1 | Output enable for `sck_o` |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The properties assume that `int_clk_sel` and `divisor` change only while no character is in flight. They also assume that an external clock holds each level for at least two system clocks, so the synchronizer never loses an edge. The stimulus changes mode and divisor only after the line has gone quiet. It drives `sck_i` with half-periods of eight system clocks and changes `sdi` only on its falling edges. The properties also take for granted that the receiver's bit count starts aligned with the first character after reset. The bench meets this by sending only whole characters.

// File: rtl/csync_pkg.sv
`timescale 1ns/1ps
package csync_pkg;
   // one-cycle strobes marking the serial clock edge acted on this cycle
   typedef struct packed {
      logic fall;
      logic rise;
   } sck_evt_t;
endpackage

// File: rtl/csync_clkgen.sv
`timescale 1ns/1ps
module csync_clkgen #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  int_sel,
   input  logic [DIV_W-1:0]      divisor,
   input  logic                  pending,
   input  logic                  sck_i,
   output csync_pkg::sck_evt_t   evt,
   output logic                  sck_o,
   output logic                  run
);
   localparam int unsigned HP_N = 2 * DATA_W;
   localparam int unsigned HP_W = $clog2(HP_N);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("csync_clkgen: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("csync_clkgen: DIV_W must be at least 1");
      end
   endgenerate

   // internal divider
   logic [DIV_W-1:0] cnt_q;
   logic [HP_W-1:0]  hp_q;
   logic             sck_q, run_q, term;
   logic             int_fall, int_rise;

   assign term     = run_q && (cnt_q == divisor);
   assign int_fall = term && sck_q;
   assign int_rise = term && !sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hp_q  <= '0;
         sck_q <= 1'b1;
         run_q <= 1'b0;
      end else if (!int_sel) begin
         cnt_q <= '0;
         hp_q  <= '0;
         sck_q <= 1'b1;
         run_q <= 1'b0;
      end else if (!run_q) begin
         cnt_q <= '0;
         hp_q  <= '0;
         sck_q <= 1'b1;
         if (pending) run_q <= 1'b1;
      end else if (term) begin
         cnt_q <= '0;
         sck_q <= !sck_q;
         if (hp_q == HP_W'(HP_N - 1)) begin
            hp_q <= '0;
            if (!pending) run_q <= 1'b0;
         end else begin
            hp_q <= hp_q + HP_W'(1);
         end
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // external clock: synchronizer plus edge detect
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q, ext_now;
   logic                   ext_fall, ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '1;
         ext_prev_q <= 1'b1;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], sck_i};
         ext_prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_now  = sync_q[SYNC_STAGES-1];
   assign ext_fall = ext_prev_q && !ext_now;
   assign ext_rise = !ext_prev_q && ext_now;

   always_comb begin
      if (int_sel) begin
         evt.fall = int_fall;
         evt.rise = int_rise;
      end else begin
         evt.fall = ext_fall;
         evt.rise = ext_rise;
      end
   end

   assign sck_o = sck_q;
   assign run   = run_q;
endmodule

// File: rtl/csync_tx.sv
`timescale 1ns/1ps
module csync_tx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              fall,
   output logic              empty,
   output logic              pending,
   output logic              sdo
);
   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] buf_q, sh_q;
   logic              buf_full_q, sh_valid_q, sdo_q;
   logic [CNT_W-1:0]  nbits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q      <= '0;
         sh_q       <= '0;
         buf_full_q <= 1'b0;
         sh_valid_q <= 1'b0;
         nbits_q    <= '0;
         sdo_q      <= 1'b1;
      end else begin
         if (wr && !buf_full_q) begin
            buf_q      <= wdata;
            buf_full_q <= 1'b1;
         end
         if (!sh_valid_q && buf_full_q) begin
            sh_q       <= buf_q;
            buf_full_q <= 1'b0;
            sh_valid_q <= 1'b1;
            nbits_q    <= '0;
         end else if (sh_valid_q && fall) begin
            sdo_q   <= sh_q[0];
            sh_q    <= {1'b0, sh_q[DATA_W-1:1]};
            nbits_q <= nbits_q + CNT_W'(1);
            if (nbits_q == LAST) sh_valid_q <= 1'b0;
         end
      end
   end

   assign empty   = !buf_full_q;
   assign pending = buf_full_q || sh_valid_q;
   assign sdo     = sdo_q;
endmodule

// File: rtl/csync_rx.sv
`timescale 1ns/1ps
module csync_rx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              sdi,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic              ovr
);
   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q, buf_q, next_sh;
   logic [CNT_W-1:0]  nbits_q;
   logic              full_q, ovr_q, done;

   assign next_sh = {sdi, sh_q[DATA_W-1:1]};
   assign done    = rise && (nbits_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         buf_q   <= '0;
         nbits_q <= '0;
         full_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (rise) begin
            sh_q    <= next_sh;
            nbits_q <= done ? '0 : nbits_q + CNT_W'(1);
         end
         if (done && (!full_q || rd)) begin
            buf_q  <= next_sh;
            full_q <= 1'b1;
         end else if (rd) begin
            full_q <= 1'b0;
         end
         if (rd)                  ovr_q <= 1'b0;
         else if (done && full_q) ovr_q <= 1'b1;
      end
   end

   assign rdata = buf_q;
   assign full  = full_q;
   assign ovr   = ovr_q;
endmodule

// File: rtl/csync_xcvr.sv
`timescale 1ns/1ps
module csync_xcvr #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_clk_sel,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic              tx_empty,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rx_rd,
   output logic              rx_full,
   output logic              rx_ovr,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   output logic              sdo,
   input  logic              sdi
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("csync_xcvr: DATA_W must be at least 2");
      end
   endgenerate

   csync_pkg::sck_evt_t evt;
   logic                tx_pending, clk_run, fall_evt, rise_evt;

   csync_clkgen #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_clk (
      .clk(clk), .rst_n(rst_n), .int_sel(int_clk_sel), .divisor(divisor),
      .pending(tx_pending), .sck_i(sck_i), .evt(evt), .sck_o(sck_o),
      .run(clk_run)
   );

   assign fall_evt = evt.fall;
   assign rise_evt = evt.rise;

   csync_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .wdata(tx_data), .wr(tx_wr),
      .fall(fall_evt), .empty(tx_empty), .pending(tx_pending), .sdo(sdo)
   );

   csync_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise(rise_evt), .sdi(sdi), .rd(rx_rd),
      .rdata(rx_data), .full(rx_full), .ovr(rx_ovr)
   );

   assign sck_oe = int_clk_sel;
endmodule

// File: rtl/csync_xcvr_chk.sv
`timescale 1ns/1ps
module csync_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic sdo,
   input logic fall_evt,
   input logic rise_evt,
   input logic clk_run,
   input logic sck_o,
   input logic rx_full,
   input logic rx_ovr,
   input logic rx_rd,
   input logic tx_empty,
   input logic tx_wr
);
   // R2
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_evt |=> $stable(sdo));

   // R4
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_run |-> sck_o);

   // R4
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_evt && rise_evt));

   // R8
   ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> rx_full);

   // R8
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(rx_rd));

   // R6
   empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(tx_wr));
endmodule

bind csync_xcvr csync_xcvr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sdo(sdo), .fall_evt(fall_evt),
   .rise_evt(rise_evt), .clk_run(clk_run), .sck_o(sck_o),
   .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_rd(rx_rd),
   .tx_empty(tx_empty), .tx_wr(tx_wr)
);

// File: tb/tb_csync_xcvr.sv
`timescale 1ns/1ps
module tb_csync_xcvr;
   localparam int DW  = 8;
   localparam int VW  = 8;
   localparam int DIV = 3;
   localparam int PER_NS = 2 * (DIV + 1) * 20;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          int_clk_sel = 1'b1;
   logic [VW-1:0] divisor = VW'(DIV);
   logic [DW-1:0] tx_data = '0, rx_data;
   logic          tx_wr = 1'b0, rx_rd = 1'b0, tx_empty, rx_full, rx_ovr;
   logic          sck_i = 1'b1, sck_o, sck_oe, sdo, sdi;
   logic          lb = 1'b1, sdi_drv = 1'b0;

   assign sdi = lb ? sdo : sdi_drv;

   always #10 clk = ~clk;

   csync_xcvr #(.DATA_W(DW), .DIV_W(VW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .int_clk_sel(int_clk_sel), .divisor(divisor),
      .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty),
      .rx_data(rx_data), .rx_rd(rx_rd), .rx_full(rx_full), .rx_ovr(rx_ovr),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
   );

   int n_chk = 0, n_err = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // line monitor for internal mode
   logic [DW-1:0] cap [0:7];
   logic [DW-1:0] acc = '0;
   int  cap_n = 0, bitn = 0, nfall = 0;
   longint fall_t [0:31];
   longint rise_t0 = 0;

   always @(posedge sck_o) begin
      if (cap_n == 0 && bitn == 0) rise_t0 = $time;
      acc = {sdo, acc[DW-1:1]};
      bitn++;
      if (bitn == DW) begin
         cap[cap_n % 8] = acc;
         cap_n++;
         bitn = 0;
      end
   end

   always @(negedge sck_o) begin
      if (nfall < 32) fall_t[nfall] = $time;
      nfall++;
   end

   task automatic mon_clear();
      cap_n = 0; bitn = 0; nfall = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_byte(input logic [DW-1:0] b);
      @(negedge clk); tx_data = b; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cyc(4);
      check("R1", "tx_empty", 32'(tx_empty), 1);
      check("R1", "rx_full", 32'(rx_full), 0);
      check("R1", "rx_ovr", 32'(rx_ovr), 0);
      check("R1", "sck_o", 32'(sck_o), 1);
      check("R1", "sdo", 32'(sdo), 1);
      rst_n = 1'b1;
      cyc(3);
      check("R4", "sck_oe internal", 32'(sck_oe), 1);
   endtask

   task automatic t_single();
      lb = 1'b1; mon_clear();
      wr_byte(8'h4B);
      cyc(90);
      check("R2", "sent byte", 32'(cap[0]), 32'h4B);
      check("R4", "pulses per char", 32'(nfall), 8);
      check("R4", "first edge falling", 32'(fall_t[0] < rise_t0), 1);
      check("R4", "clock period ns", 32'(fall_t[1] - fall_t[0]), PER_NS);
      check("R4", "idle high", 32'(sck_o), 1);
      check("R3", "rx_full", 32'(rx_full), 1);
      check("R3", "rx_data", 32'(rx_data), 32'h4B);
      check("R5", "msb hold 0", 32'(sdo), 0);
      rd_pulse();
      check("R8", "read clears full", 32'(rx_full), 0);
   endtask

   task automatic t_back_to_back();
      mon_clear();
      wr_byte(8'hC3);
      cyc(3);
      check("R6", "empty after load", 32'(tx_empty), 1);
      wr_byte(8'h96);
      cyc(70);
      check("R3", "first rx byte", 32'(rx_data), 32'hC3);
      rd_pulse();
      cyc(80);
      check("R2", "char 0", 32'(cap[0]), 32'hC3);
      check("R2", "char 1", 32'(cap[1]), 32'h96);
      check("R4", "pulses two chars", 32'(nfall), 16);
      check("R6", "no gap between chars", 32'(fall_t[8] - fall_t[7]), PER_NS);
      check("R6", "second rx byte", 32'(rx_data), 32'h96);
      check("R8", "no overrun when read", 32'(rx_ovr), 0);
      check("R5", "msb hold 1", 32'(sdo), 1);
      cyc(30);
      check("R5", "msb still held", 32'(sdo), 1);
      rd_pulse();
   endtask

   task automatic t_ignore_and_overrun();
      mon_clear();
      wr_byte(8'h11);
      cyc(2);
      wr_byte(8'h22);
      check("R6", "buffer full", 32'(tx_empty), 0);
      wr_byte(8'h33);
      cyc(160);
      check("R7", "chars sent", 32'(cap_n), 2);
      check("R7", "waiting byte kept", 32'(cap[1]), 32'h22);
      check("R8", "overrun set", 32'(rx_ovr), 1);
      check("R8", "old byte kept", 32'(rx_data), 32'h11);
      rd_pulse();
      check("R8", "read clears ovr", 32'(rx_ovr), 0);
      check("R8", "read clears full", 32'(rx_full), 0);
   endtask

   task automatic t_external();
      logic [DW-1:0] got = '0;
      logic [DW-1:0] in_b = 8'h5A;
      int_clk_sel = 1'b0; lb = 1'b0;
      cyc(4);
      check("R9", "sck_oe external", 32'(sck_oe), 0);
      wr_byte(8'hE1);
      cyc(2);
      for (int i = 0; i < DW; i++) begin
         sck_i = 1'b0; sdi_drv = in_b[i];
         cyc(8);
         got[i] = sdo;
         sck_i = 1'b1;
         cyc(8);
      end
      cyc(6);
      check("R9", "ext tx byte", 32'(got), 32'hE1);
      check("R9", "ext rx byte", 32'(rx_data), 32'h5A);
      check("R9", "ext rx_full", 32'(rx_full), 1);
      check("R9", "sck_o high external", 32'(sck_o), 1);
      check("R5", "ext msb hold", 32'(sdo), 1);
   endtask

   initial begin
      #400000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      t_back_to_back();
      t_ignore_and_overrun();
      t_external();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule